// File: doc/BRIEF.md
# Private Interrupt State Register Bank

This block is the per-processor store for the thirty-two private interrupts of one core: sixteen software-generated and sixteen peripheral. For every interrupt it keeps a group bit, a group-modifier bit, enable, pending and active flags, an 8-bit priority and, for the peripheral half, a trigger-mode bit. Each software-generated interrupt also has a 2-bit non-secure access level. The core-wake state is a single sleep flag.

Software reaches this state over a simple word-addressed register bus. Each access carries a secure flag, and one global input turns the two-world security model off. With security on, a non-secure access sees only the interrupts that resolve to non-secure group 1. It also sees priorities through a halved view in which the top bit is forced. From the stored bits the block resolves a 2-bit group code for every interrupt and drives it out registered, for the prioritisation logic further on.

Top module: `pirq_state_bank`

## Requirements
- R1: With `sec_disable` low, interrupt i's group code on `irq_group[2i+1:2i]` is 2'b00 (secure group 0) when its (modifier, group) bits are 00, 2'b01 (non-secure group 1) for 01 or 11, and 2'b10 (secure group 1) for 10. The output is registered, so it reflects state and inputs one clock later.
- R2: With `sec_disable` high, the group bit alone selects the code: 0 gives 2'b00 and 1 gives 2'b01. Code 2'b10 never appears.
- R3: Enable, pending and active each have a set address and a clear address. A 1 in the write data sets or clears that interrupt's bit, and a 0 leaves it unchanged. Both addresses read the current vector, with bit i for interrupt i.
- R4: When `sec_disable` is low and `bus_secure` is low, every interrupt whose code is not 2'b01 reads as zero and ignores writes. This applies in the enable, pending, active, trigger-configuration and priority registers.
- R5: A non-secure access with security on stores 0x80 | (byte >> 1) as the priority. It reads the stored value shifted left by one and truncated to 8 bits.
- R6: Priority word 16+k holds interrupts 4k..4k+3, with interrupt 4k+b in byte lane b (bits 8b+7:8b). Only lanes whose `wstrb` bit is set are written.
- R7: In both configuration words, bit 2j+1 reports edge trigger for the j-th interrupt of the word, and even bits read zero. The software-generated word (address 9) always reads its odd bits as 1 and ignores writes. The peripheral word (address 10) stores bit 2j+1 for interrupt 16+j.
- R8: The group register and the wake register read zero and ignore writes for non-secure accesses when security is on. The modifier and access-level registers read zero and ignore writes unless the access is secure and `sec_disable` is low.
- R9: The access-level register holds 2 bits per software-generated interrupt i, at bits 2i+1:2i.
- R10: In the wake register, write bit 0 sets the sleep flag directly. A read returns bit 0 (sleep) and bit 1 (children asleep) both equal to the sleep flag.
- R11: Reset clears group, modifier, enable, pending, active, priority, peripheral trigger and access-level state. It sets the sleep flag to 1 and leaves every group code at 2'b00.
- R12: Word addresses: 0 wake, 1 group, 2 modifier, 3/4 enable set/clear, 5/6 pending set/clear, 7/8 active set/clear, 9/10 configuration, 11 access level, 16..23 priority. `rd_data` carries the word addressed in the cycle `rd_en` was high, one clock later. Other addresses read zero and ignore writes. Registers other than priority take the whole word regardless of `wstrb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | High turns the two-world security model off |
| bus_secure | input | 1 | Current access is secure |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane enables for priority writes |
| rd_data | output | 32 | Registered read data |
| irq_group | output | 64 | Registered 2-bit group code per interrupt |

## Verification
Group resolution is swept over a pattern that covers all four (modifier, group) pairs, then over pseudo-random vectors, with security both on and off. This separates the modifier-driven secure group 1 from the non-secure cases.

Every priority word is written under all fifteen non-empty strobe masks. This exposes lane-to-interrupt swaps and writes through masked lanes.

The set/clear pairs and the filters are then driven with all-ones and mixed vectors from a secure view and a non-secure view. After each stimulus every mapped register is read back in both views. A missing filter, a bad non-secure priority transform, or a write that lands in the wrong interrupt then shows up as a mismatch against the bench model.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [1:0] {
    GRP_S0  = 2'b00,
    GRP_NS1 = 2'b01,
    GRP_S1  = 2'b10
  } grp_code_e;

  localparam int unsigned A_WAKE    = 0;
  localparam int unsigned A_GROUP   = 1;
  localparam int unsigned A_GMOD    = 2;
  localparam int unsigned A_EN_SET  = 3;
  localparam int unsigned A_EN_CLR  = 4;
  localparam int unsigned A_PD_SET  = 5;
  localparam int unsigned A_PD_CLR  = 6;
  localparam int unsigned A_AC_SET  = 7;
  localparam int unsigned A_AC_CLR  = 8;
  localparam int unsigned A_CFG_SGI = 9;
  localparam int unsigned A_CFG_PPI = 10;
  localparam int unsigned A_NSAC    = 11;
  localparam int unsigned A_PRIO0   = 16;
endpackage

// File: rtl/pirq_grp_resolve.sv
module pirq_grp_resolve
  import pirq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]   grp_bits,
  input  logic [N-1:0]   mod_bits,
  input  logic           sec_off,
  output logic [2*N-1:0] code
);
  for (genvar i = 0; i < N; i++) begin : g_irq
    grp_code_e c;
    always_comb begin
      if (grp_bits[i])                  c = GRP_NS1;
      else if (!sec_off && mod_bits[i]) c = GRP_S1;
      else                              c = GRP_S0;
    end
    assign code[2*i +: 2] = c;
  end
endmodule

// File: rtl/pirq_setclr_vec.sv
module pirq_setclr_vec #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] bits,
  input  logic [N-1:0] allow,
  output logic [N-1:0] q
);
  logic [N-1:0] hit;
  assign hit = bits & allow;

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_we) q <= q | hit;
    else if (clr_we) q <= q & ~hit;
  end
endmodule

// File: rtl/pirq_prio_store.sv
module pirq_prio_store #(
  parameter int N      = 32,
  parameter int PW     = 8,
  parameter int LANES  = 4,
  parameter int WIDX_W = $clog2(N / LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WIDX_W-1:0]   widx,
  input  logic [LANES-1:0]    wstrb,
  input  logic [LANES*PW-1:0] wdata,
  input  logic                ns_view,
  input  logic [N-1:0]        allow,
  output logic [LANES*PW-1:0] rd_word
);
  localparam int LW    = $clog2(LANES);
  localparam int IDX_W = WIDX_W + LW;

  logic [N-1:0][PW-1:0]     prio_q;
  logic [LANES-1:0][PW-1:0] lane_wr;

  // Per-lane stored value: raw, or halved with top bit forced in the non-secure view.
  for (genvar l = 0; l < LANES; l++) begin : g_wlane
    assign lane_wr[l] = ns_view ? {1'b1, wdata[l*PW+1 +: PW-1]} : wdata[l*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
    end else if (wr_en) begin
      for (int e = 0; e < N; e++) begin
        if (widx == WIDX_W'(e / LANES) && wstrb[e % LANES] && allow[e])
          prio_q[e] <= lane_wr[e % LANES];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rlane
    logic [IDX_W-1:0] ridx;
    logic [PW-1:0]    val;
    assign ridx = {widx, LW'(l)};
    assign val  = prio_q[ridx];
    assign rd_word[l*PW +: PW] = !allow[ridx] ? '0 :
                                 ns_view      ? {val[PW-2:0], 1'b0} : val;
  end
endmodule

// File: rtl/pirq_state_bank.sv
module pirq_state_bank
  import pirq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sec_disable,
  input  logic                     bus_secure,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/PRIO_W-1:0] wstrb,
  output logic [DATA_W-1:0]        rd_data,
  output logic [2*(NUM_SGI+NUM_PPI)-1:0] irq_group
);
  localparam int N          = NUM_SGI + NUM_PPI;
  localparam int LANES      = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = N / LANES;
  localparam int WIDX_W     = $clog2(PRIO_WORDS);

  localparam logic [ADDR_W-1:0] AD_WAKE    = ADDR_W'(A_WAKE);
  localparam logic [ADDR_W-1:0] AD_GROUP   = ADDR_W'(A_GROUP);
  localparam logic [ADDR_W-1:0] AD_GMOD    = ADDR_W'(A_GMOD);
  localparam logic [ADDR_W-1:0] AD_EN_SET  = ADDR_W'(A_EN_SET);
  localparam logic [ADDR_W-1:0] AD_EN_CLR  = ADDR_W'(A_EN_CLR);
  localparam logic [ADDR_W-1:0] AD_PD_SET  = ADDR_W'(A_PD_SET);
  localparam logic [ADDR_W-1:0] AD_PD_CLR  = ADDR_W'(A_PD_CLR);
  localparam logic [ADDR_W-1:0] AD_AC_SET  = ADDR_W'(A_AC_SET);
  localparam logic [ADDR_W-1:0] AD_AC_CLR  = ADDR_W'(A_AC_CLR);
  localparam logic [ADDR_W-1:0] AD_CFG_SGI = ADDR_W'(A_CFG_SGI);
  localparam logic [ADDR_W-1:0] AD_CFG_PPI = ADDR_W'(A_CFG_PPI);
  localparam logic [ADDR_W-1:0] AD_NSAC    = ADDR_W'(A_NSAC);
  localparam logic [ADDR_W-1:0] AD_PRIO0   = ADDR_W'(A_PRIO0);

  // Architectural state
  logic [N-1:0]         grp_q, mod_q, en_q, pend_q, act_q;
  logic [NUM_PPI-1:0]   ppicfg_q;
  logic [2*NUM_SGI-1:0] nsac_q;
  logic                 sleep_q;

  logic                 ns_lim;    // non-secure access while security is on
  logic                 sec_full;  // secure access while security is on
  logic [2*N-1:0]       code_c;
  logic [N-1:0]         vis;
  logic [ADDR_W-1:0]    prio_off;
  logic                 in_prio;
  logic [DATA_W-1:0]    prio_word, rd_c;

  assign ns_lim   = !sec_disable && !bus_secure;
  assign sec_full = !sec_disable && bus_secure;
  assign prio_off = addr - AD_PRIO0;
  assign in_prio  = (addr >= AD_PRIO0) && (prio_off < ADDR_W'(PRIO_WORDS));

  pirq_grp_resolve #(.N(N)) u_resolve (
    .grp_bits (grp_q),
    .mod_bits (mod_q),
    .sec_off  (sec_disable),
    .code     (code_c)
  );

  for (genvar i = 0; i < N; i++) begin : g_vis
    assign vis[i] = !ns_lim || (code_c[2*i +: 2] == GRP_NS1);
  end

  pirq_setclr_vec #(.N(N)) u_en (
    .clk (clk), .rst (rst),
    .set_we (wr_en && addr == AD_EN_SET), .clr_we (wr_en && addr == AD_EN_CLR),
    .bits (wdata[N-1:0]), .allow (vis), .q (en_q)
  );
  pirq_setclr_vec #(.N(N)) u_pend (
    .clk (clk), .rst (rst),
    .set_we (wr_en && addr == AD_PD_SET), .clr_we (wr_en && addr == AD_PD_CLR),
    .bits (wdata[N-1:0]), .allow (vis), .q (pend_q)
  );
  pirq_setclr_vec #(.N(N)) u_act (
    .clk (clk), .rst (rst),
    .set_we (wr_en && addr == AD_AC_SET), .clr_we (wr_en && addr == AD_AC_CLR),
    .bits (wdata[N-1:0]), .allow (vis), .q (act_q)
  );

  pirq_prio_store #(.N(N), .PW(PRIO_W), .LANES(LANES), .WIDX_W(WIDX_W)) u_prio (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && in_prio),
    .widx    (prio_off[WIDX_W-1:0]),
    .wstrb   (wstrb),
    .wdata   (wdata),
    .ns_view (ns_lim),
    .allow   (vis),
    .rd_word (prio_word)
  );

  // Register writes outside the set/clear vectors and priorities
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q    <= '0;
      mod_q    <= '0;
      ppicfg_q <= '0;
      nsac_q   <= '0;
      sleep_q  <= 1'b1;
    end else if (wr_en) begin
      case (addr)
        AD_WAKE:    if (!ns_lim)  sleep_q <= wdata[0];
        AD_GROUP:   if (!ns_lim)  grp_q   <= wdata[N-1:0];
        AD_GMOD:    if (sec_full) mod_q   <= wdata[N-1:0];
        AD_NSAC:    if (sec_full) nsac_q  <= wdata[2*NUM_SGI-1:0];
        AD_CFG_PPI: begin
          for (int j = 0; j < NUM_PPI; j++) begin
            if (vis[NUM_SGI+j]) ppicfg_q[j] <= wdata[2*j+1];
          end
        end
        default: ;
      endcase
    end
  end

  // Read multiplexer
  always_comb begin
    rd_c = '0;
    case (addr)
      AD_WAKE:              if (!ns_lim)  rd_c[1:0] = {sleep_q, sleep_q};
      AD_GROUP:             if (!ns_lim)  rd_c[N-1:0] = grp_q;
      AD_GMOD:              if (sec_full) rd_c[N-1:0] = mod_q;
      AD_EN_SET, AD_EN_CLR: rd_c[N-1:0] = en_q & vis;
      AD_PD_SET, AD_PD_CLR: rd_c[N-1:0] = pend_q & vis;
      AD_AC_SET, AD_AC_CLR: rd_c[N-1:0] = act_q & vis;
      AD_NSAC:              if (sec_full) rd_c[2*NUM_SGI-1:0] = nsac_q;
      AD_CFG_SGI: begin
        for (int i = 0; i < NUM_SGI; i++) rd_c[2*i+1] = vis[i];
      end
      AD_CFG_PPI: begin
        for (int j = 0; j < NUM_PPI; j++) rd_c[2*j+1] = ppicfg_q[j] & vis[NUM_SGI+j];
      end
      default: if (in_prio) rd_c = prio_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      irq_group <= '0;
    end else begin
      if (rd_en) rd_data <= rd_c;
      irq_group <= code_c;
    end
  end
endmodule

// File: rtl/pirq_state_bank_chk.sv
module pirq_state_bank_chk
  import pirq_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_disable,
  input logic              bus_secure,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic [2*N-1:0]    irq_group,
  input logic [N-1:0]      grp_q,
  input logic [N-1:0]      mod_q,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      act_q,
  input logic              sleep_q
);
  logic [2*N-1:0] exp_code;
  logic [N-1:0]   s1_bits;
  logic           rst_d = 1'b0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      exp_code[2*i +: 2] = grp_q[i] ? 2'b01 : ((!sec_disable && mod_q[i]) ? 2'b10 : 2'b00);
      s1_bits[i]         = irq_group[2*i+1];
    end
  end

  p_code_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_group == $past(exp_code));

  p_no_s1_r2: assert property (@(posedge clk) disable iff (rst)
    sec_disable |=> s1_bits == '0);

  p_set_en_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_secure && addr == ADDR_W'(A_EN_SET))
    |=> (en_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0]));

  p_clr_pend_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_secure && addr == ADDR_W'(A_PD_CLR))
    |=> (pend_q & $past(wdata[N-1:0])) == '0);

  p_ns_en_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bus_secure && !sec_disable &&
     (addr == ADDR_W'(A_EN_SET) || addr == ADDR_W'(A_EN_CLR)))
    |=> ((en_q ^ $past(en_q)) & ~$past(grp_q)) == '0);

  p_wake_raz_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !bus_secure && !sec_disable && addr == ADDR_W'(A_WAKE)) |=> rd_data == '0);

  p_gmod_raz_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sec_disable && addr == ADDR_W'(A_GMOD)) |=> rd_data == '0);

  p_wake_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (bus_secure || sec_disable) && addr == ADDR_W'(A_WAKE))
    |=> rd_data == DATA_W'({2{$past(sleep_q)}}));

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      p_reset_r11: assert (en_q == '0 && pend_q == '0 && act_q == '0 &&
                           grp_q == '0 && mod_q == '0 && sleep_q)
        else $error("reset state wrong");
    end
  end
endmodule

bind pirq_state_bank pirq_state_bank_chk #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk (clk), .rst (rst), .sec_disable (sec_disable), .bus_secure (bus_secure),
  .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .wdata (wdata), .rd_data (rd_data),
  .irq_group (irq_group), .grp_q (grp_q), .mod_q (mod_q), .en_q (en_q),
  .pend_q (pend_q), .act_q (act_q), .sleep_q (sleep_q)
);

// File: tb/pirq_state_bank_tb.sv
module pirq_state_bank_tb;
  logic        clk = 1'b0, rst = 1'b1, sec_disable = 1'b0, bus_secure = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [31:0] rd_data;
  logic [63:0] irq_group;

  always #5 clk = ~clk;

  pirq_state_bank u_dut (
    .clk (clk), .rst (rst), .sec_disable (sec_disable), .bus_secure (bus_secure),
    .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .wdata (wdata), .wstrb (wstrb),
    .rd_data (rd_data), .irq_group (irq_group)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;

  // Bench model built from the requirements
  logic [31:0] m_grp, m_mod, m_en, m_pd, m_ac, m_nsac;
  logic [15:0] m_cfg;
  logic        m_sleep;
  logic [7:0]  m_prio [32];

  function automatic logic [31:0] nx(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  function automatic bit nsl(bit sec);
    return !sec_disable && !sec;
  endfunction

  function automatic bit vis(int i, bit sec);
    return !nsl(sec) || m_grp[i];
  endfunction

  task automatic model_reset();
    m_grp = '0; m_mod = '0; m_en = '0; m_pd = '0; m_ac = '0; m_nsac = '0;
    m_cfg = '0; m_sleep = 1'b1;
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
  endtask

  function automatic logic [31:0] exp_rd(int a, bit sec);
    logic [31:0] r = '0;
    case (a)
      0:    if (!nsl(sec)) r = {30'b0, m_sleep, m_sleep};
      1:    if (!nsl(sec)) r = m_grp;
      2:    if (!sec_disable && sec) r = m_mod;
      3, 4: for (int i = 0; i < 32; i++) r[i] = m_en[i] & vis(i, sec);
      5, 6: for (int i = 0; i < 32; i++) r[i] = m_pd[i] & vis(i, sec);
      7, 8: for (int i = 0; i < 32; i++) r[i] = m_ac[i] & vis(i, sec);
      9:    for (int i = 0; i < 16; i++) r[2*i+1] = vis(i, sec);
      10:   for (int j = 0; j < 16; j++) r[2*j+1] = m_cfg[j] & vis(16+j, sec);
      11:   if (!sec_disable && sec) r = m_nsac;
      16, 17, 18, 19, 20, 21, 22, 23: begin
        for (int b = 0; b < 4; b++) begin
          int i = (a - 16) * 4 + b;
          if (vis(i, sec)) r[8*b +: 8] = nsl(sec) ? {m_prio[i][6:0], 1'b0} : m_prio[i];
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic apply_wr(int a, logic [31:0] d, logic [3:0] s, bit sec);
    logic [31:0] ok;
    for (int i = 0; i < 32; i++) ok[i] = vis(i, sec);
    case (a)
      0:  if (!nsl(sec)) m_sleep = d[0];
      1:  if (!nsl(sec)) m_grp = d;
      2:  if (!sec_disable && sec) m_mod = d;
      3:  m_en = m_en | (d & ok);
      4:  m_en = m_en & ~(d & ok);
      5:  m_pd = m_pd | (d & ok);
      6:  m_pd = m_pd & ~(d & ok);
      7:  m_ac = m_ac | (d & ok);
      8:  m_ac = m_ac & ~(d & ok);
      10: for (int j = 0; j < 16; j++) if (ok[16+j]) m_cfg[j] = d[2*j+1];
      11: if (!sec_disable && sec) m_nsac = d;
      16, 17, 18, 19, 20, 21, 22, 23: begin
        for (int b = 0; b < 4; b++) begin
          int i = (a - 16) * 4 + b;
          if (s[b] && ok[i]) m_prio[i] = nsl(sec) ? {1'b1, d[8*b+1 +: 7]} : d[8*b +: 8];
        end
      end
      default: ;
    endcase
  endtask

  task automatic check(logic [63:0] act, logic [63:0] exp, string tag, int a);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] s, bit sec);
    @(negedge clk);
    addr = a[4:0]; wdata = d; wstrb = s; bus_secure = sec; wr_en = 1'b1;
    apply_wr(a, d, s, sec);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, bit sec, string tag);
    @(negedge clk);
    addr = a[4:0]; bus_secure = sec; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check({32'b0, rd_data}, {32'b0, exp_rd(a, sec)}, tag, a);
  endtask

  task automatic check_all(string tag);
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 24; a++) if (a < 12 || a >= 16) rd_chk(a, s[0], tag);
      rd_chk(12, s[0], tag);
      rd_chk(31, s[0], tag);
    end
  endtask

  task automatic chk_grp(string tag);
    logic [63:0] e;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 32; i++)
      e[2*i +: 2] = m_grp[i] ? 2'b01 : ((!sec_disable && m_mod[i]) ? 2'b10 : 2'b00);
    check(irq_group, e, tag, 64);
  endtask

  initial begin
    logic [31:0] lf = 32'h1234_5678;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    chk_grp("R11");
    check_all("R11");

    // R1 / R2: group resolution sweep
    for (int p = 0; p < 6; p++) begin
      sec_disable = 1'b0;
      wr(1, (p == 0) ? 32'hCCCC_CCCC : lf, 4'hF, 1'b1);
      lf = nx(lf);
      wr(2, (p == 0) ? 32'hAAAA_AAAA : lf, 4'hF, 1'b1);
      lf = nx(lf);
      for (int sd = 0; sd < 2; sd++) begin
        sec_disable = sd[0];
        chk_grp(sd == 0 ? "R1" : "R2");
      end
    end
    sec_disable = 1'b0;
    check_all("R1");

    // R3: set/clear pairs, secure
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < 3; r++) begin
        wr(3 + 2*k, lf, 4'hF, 1'b1);  lf = nx(lf);
        rd_chk(3 + 2*k, 1'b1, "R3");
        wr(4 + 2*k, lf, 4'hF, 1'b1);  lf = nx(lf);
        rd_chk(4 + 2*k, 1'b1, "R3");
      end
      wr(3 + 2*k, 32'h0, 4'hF, 1'b1);
      rd_chk(3 + 2*k, 1'b1, "R3");
      wr(4 + 2*k, 32'h0, 4'hF, 1'b1);
      rd_chk(4 + 2*k, 1'b1, "R3");
    end
    check_all("R3");

    // R4: non-secure filtering with mixed groups
    wr(1, 32'h0F0F_5A5A, 4'hF, 1'b1);
    wr(2, 32'h3333_3333, 4'hF, 1'b1);
    wr(3, 32'hFFFF_FFFF, 4'hF, 1'b0);
    wr(5, 32'hFFFF_FFFF, 4'hF, 1'b0);
    wr(7, 32'hFFFF_FFFF, 4'hF, 1'b0);
    wr(10, 32'hFFFF_FFFF, 4'hF, 1'b0);
    for (int w = 0; w < 8; w++) begin
      wr(16 + w, lf, 4'hF, 1'b0); lf = nx(lf);
    end
    check_all("R4");
    wr(4, 32'hFFFF_FFFF, 4'hF, 1'b0);
    wr(6, 32'hFFFF_FFFF, 4'hF, 1'b0);
    wr(8, 32'h5555_5555, 4'hF, 1'b0);
    check_all("R4");

    // R8: non-secure writes to secure-only registers ignored
    wr(1, 32'h0000_0000, 4'hF, 1'b0);
    wr(2, 32'hFFFF_FFFF, 4'hF, 1'b0);
    wr(11, 32'hFFFF_FFFF, 4'hF, 1'b0);
    wr(0, 32'h0, 4'hF, 1'b0);
    check_all("R8");

    // R6: priority lanes under every strobe mask
    for (int w = 0; w < 8; w++) begin
      for (int s = 1; s < 16; s++) begin
        wr(16 + w, lf, s[3:0], 1'b1); lf = nx(lf);
        rd_chk(16 + w, 1'b1, "R6");
      end
    end

    // R5: non-secure priority view
    wr(1, 32'hFFFF_FFFF, 4'hF, 1'b1);
    for (int w = 0; w < 8; w++) begin
      wr(16 + w, lf, 4'hF, 1'b0); lf = nx(lf);
      rd_chk(16 + w, 1'b0, "R5");
      rd_chk(16 + w, 1'b1, "R5");
    end

    // R7: trigger configuration
    wr(10, lf, 4'hF, 1'b1); lf = nx(lf);
    wr(9, 32'h0, 4'hF, 1'b1);
    wr(1, 32'h00FF_0F0F, 4'hF, 1'b1);
    check_all("R7");

    // R9 / R8: access levels and security-off behaviour
    wr(11, lf, 4'hF, 1'b1); lf = nx(lf);
    check_all("R9");
    sec_disable = 1'b1;
    wr(11, ~lf, 4'hF, 1'b1);
    wr(2, lf, 4'hF, 1'b1);
    check_all("R8");
    chk_grp("R2");
    sec_disable = 1'b0;
    rd_chk(11, 1'b1, "R9");

    // R10: wake register
    wr(0, 32'h0, 4'hF, 1'b1);
    rd_chk(0, 1'b1, "R10");
    wr(0, 32'h1, 4'hF, 1'b0);
    rd_chk(0, 1'b1, "R10");
    wr(0, 32'hFFFF_FFFF, 4'hF, 1'b1);
    rd_chk(0, 1'b1, "R10");
    wr(0, 32'hFFFF_FFFE, 4'hF, 1'b1);
    rd_chk(0, 1'b1, "R10");

    // R12: unmapped addresses
    for (int a = 12; a < 32; a++) begin
      if (a < 16 || a >= 24) wr(a, 32'hFFFF_FFFF, 4'hF, 1'b1);
    end
    check_all("R12");

    // R11: reset from a busy state
    @(negedge clk); rst = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_grp("R11");
    check_all("R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule